// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the opening condition of an I2C transfer for a bus master. The host requests it by writing the start bit of a small control register. The block then watches both open-drain lines through two-flop synchronizers. It waits one baud half-phase with SDA released, pulls SDA low while SCL stays released, and then waits a second half-phase before it reports that the condition is complete. SDA stays held low after completion so that the next transfer phase can take over the bus.

Each half-phase is timed by a reloadable down-counter. The first half-phase takes its length from the low seven bits of the reload value, and the second takes it from all eight bits. If either line is seen low when the request arrives, or at any point before SDA has been pulled low, the block treats it as a bus collision and aborts. Host writes to the transmit buffer and to the control register are blocked while the sequence runs. A blocked buffer write is reported through a sticky flag.

Top module: `i2c_start_gen`

## Requirements
- R1: A start request is a `ctl_wr` with `ctl_wdata[0]`=1 while idle. When both synchronized lines are high at that edge, `sda_drive_low` rises exactly N1 clock edges after the accepting edge, where N1 is `reload[6:0]` (or 1 when that is zero).
- R2: `scl_drive_low` is never asserted. `sda_drive_low` rises only at the end of the first half-phase, and only if both synchronized lines are still high at that edge.
- R3: The start-seen flag `start_seen` is set on the same edge on which `sda_drive_low` rises.
- R4: M clock edges after `sda_drive_low` rises, `start_done` is set and `ctl_q[0]` returns to 0. M is the full 8-bit `reload` (or 1 when it is zero).
- R5: After completion, `sda_drive_low` stays asserted until the host clears `start_done` while the block is idle. It is released on that same edge.
- R6: If either synchronized line is low at the request edge, `bus_coll` is set and `ctl_q[0]` reads 0 afterwards. No drive is asserted and the block stays idle.
- R7: If either synchronized line is seen low during the first half-phase, the sequence aborts on that edge. `bus_coll` is set, `ctl_q[0]` is cleared, SDA is not driven and `start_seen` stays clear.
- R8: A `buf_wr` from the cycle after acceptance up to and including the completion cycle sets `wr_coll` and leaves `buf_q` unchanged. At any other time, `buf_wr` loads `buf_wdata` into `buf_q`.
- R9: A `ctl_wr` while the sequence runs has no effect on `ctl_q`. When idle, `ctl_wr` loads all five bits of `ctl_q`.
- R10: A reload field of zero behaves as a count of one, so each half-phase always ends.
- R11: The flags are cleared by writing one to `flag_clr`: bit 0 clears `start_seen`, bit 1 clears `start_done`, bit 2 clears `bus_coll` and bit 3 clears `wr_coll`. A set event and a clear in the same cycle leave the flag set.
- R12: After reset, every drive, flag, `ctl_q` and `buf_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data; bit 0 requests a start |
| reload | input | 8 | Baud half-phase reload value |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| flag_clr | input | 4 | Write-one-to-clear strobes for the four flags |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| scl_drive_low | output | 1 | Pull SCL low when 1 (always 0 here) |
| ctl_q | output | 5 | Control register contents |
| buf_q | output | 8 | Transmit buffer contents |
| start_seen | output | 1 | Start condition produced |
| start_done | output | 1 | Start sequence complete |
| bus_coll | output | 1 | Bus collision detected |
| wr_coll | output | 1 | Buffer write blocked during a start |

## Verification
The bench uses the default build: an 8-bit reload and two synchronizer stages. With these values, a reload of 0x85 gives a 5-cycle first half-phase and a 133-cycle second half-phase, so any mix-up between the 7-bit and 8-bit views shows up directly in the timing. A reload of zero exercises the one-cycle floor in both half-phases. A reload of 3 gives a short, symmetric case. The two synchronizer stages set the latency with which injected SDA and SCL faults reach the collision logic, so a fault raised a few cycles into a 20-cycle half-phase aborts well before SDA would be pulled low.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HOLD  = 2'd2
  } start_phase_e;

  localparam int CTL_W     = 5;
  localparam int CTL_START = 0;
  localparam int NFLAGS    = 4;
  localparam int FLAG_SEEN = 0;
  localparam int FLAG_DONE = 1;
  localparam int FLAG_BCOL = 2;
  localparam int FLAG_WCOL = 3;

  // A zero reload still yields one counted cycle.
  function automatic int unsigned clamp_count(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // The first half-phase uses the reload value without its top bit.
  function automatic int unsigned first_phase(input int unsigned raw, input int unsigned width);
    return raw % (32'd1 << (width - 1));
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int   STAGES  = 2,
  parameter logic INIT_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= {STAGES{INIT_LV}};
    else        shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/i2cs_baud.sv
module i2cs_baud
  import i2cs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         timeout,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (load)                count <= W'(clamp_count(32'(load_val)));
    else if (run && count > ONE)  count <= count - ONE;
  end

  assign timeout = run && (count == ONE);

  p_zero_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (count == ONE));

  p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && count > ONE) |=> (count == $past(count) - ONE));
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
  import i2cs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr,
  input  logic         start_bit,
  input  logic [W-1:0] reload,
  input  logic         sda_s,
  input  logic         scl_s,
  input  logic         timeout,
  input  logic         done_clr,
  output logic         cnt_load,
  output logic [W-1:0] cnt_val,
  output logic         cnt_run,
  output logic         sda_hold,
  output logic         busy,
  output logic         ev_accept,
  output logic         ev_abort,
  output logic         ev_edge,
  output logic         ev_finish
);
  start_phase_e phase, phase_nx;
  logic lines_high, request;

  assign lines_high = sda_s && scl_s;
  assign request    = (phase == PH_IDLE) && ctl_wr && start_bit;
  assign ev_accept  = request && lines_high;
  assign ev_abort   = (request && !lines_high) || ((phase == PH_SETUP) && !lines_high);
  assign ev_edge    = (phase == PH_SETUP) && lines_high && timeout;
  assign ev_finish  = (phase == PH_HOLD) && timeout;
  assign busy       = (phase != PH_IDLE);
  assign cnt_run    = busy;
  assign cnt_load   = ev_accept || ev_edge;
  assign cnt_val    = ev_accept ? W'(first_phase(32'(reload), W)) : reload;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:  if (ev_accept) phase_nx = PH_SETUP;
      PH_SETUP: if (ev_abort) phase_nx = PH_IDLE;
                else if (ev_edge) phase_nx = PH_HOLD;
      PH_HOLD:  if (ev_finish) phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      sda_hold <= 1'b0;
    end else begin
      phase <= phase_nx;
      if (ev_edge)                             sda_hold <= 1'b1;
      else if ((phase == PH_IDLE) && done_clr) sda_hold <= 1'b0;
    end
  end

  p_edge_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_edge |=> (sda_hold && phase == PH_HOLD));

  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (phase == PH_IDLE));

  p_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_hold && !done_clr) |=> sda_hold);

  p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_accept, ev_abort, ev_edge, ev_finish}));
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              buf_wr,
  input  logic [7:0]        buf_wdata,
  input  logic [NFLAGS-1:0] flag_clr,
  input  logic              busy,
  input  logic              ev_abort,
  input  logic              ev_edge,
  input  logic              ev_finish,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [7:0]        buf_q,
  output logic [NFLAGS-1:0] flags
);
  logic              wcol_ev;
  logic [NFLAGS-1:0] flag_set;

  assign wcol_ev = buf_wr && busy;

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_SEEN] = ev_edge;
    flag_set[FLAG_DONE] = ev_finish;
    flag_set[FLAG_BCOL] = ev_abort;
    flag_set[FLAG_WCOL] = wcol_ev;
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags[i] <= 1'b0;
      else if (flag_set[i]) flags[i] <= 1'b1;
      else if (flag_clr[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      buf_q <= '0;
    end else begin
      if (ctl_wr && !busy)      ctl_q <= ctl_wdata;
      if (ev_abort || ev_finish) ctl_q[CTL_START] <= 1'b0;
      if (buf_wr && !busy)      buf_q <= buf_wdata;
    end
  end

  p_wcol_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && busy) |=> (flags[FLAG_WCOL] && $stable(buf_q)));

  p_ctl_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (ctl_q[CTL_W-1:1] == $past(ctl_q[CTL_W-1:1])));

  p_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> (flags[FLAG_DONE] && !ctl_q[CTL_START]));

  p_abort_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (flags[FLAG_BCOL] && !ctl_q[CTL_START]));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_edge && flag_clr[FLAG_SEEN]) |=> flags[FLAG_SEEN]);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2cs_pkg::*;
#(
  parameter int RELOAD_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [CTL_W-1:0]    ctl_wdata,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                sda_in,
  input  logic                scl_in,
  input  logic                buf_wr,
  input  logic [7:0]          buf_wdata,
  input  logic [NFLAGS-1:0]   flag_clr,
  output logic                sda_drive_low,
  output logic                scl_drive_low,
  output logic [CTL_W-1:0]    ctl_q,
  output logic [7:0]          buf_q,
  output logic                start_seen,
  output logic                start_done,
  output logic                bus_coll,
  output logic                wr_coll
);
  localparam int NLINES = 2;

  logic [NLINES-1:0]   line_raw, line_s;
  logic                cnt_load, cnt_run, timeout, sda_hold, busy;
  logic                ev_accept, ev_abort, ev_edge, ev_finish;
  logic [RELOAD_W-1:0] cnt_val, count;
  logic [NFLAGS-1:0]   flags;

  assign line_raw = {scl_in, sda_in};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    i2cs_sync #(.STAGES(SYNC_STAGES), .INIT_LV(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_raw[i]), .q(line_s[i])
    );
  end

  i2cs_baud #(.W(RELOAD_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .run(cnt_run), .timeout(timeout), .count(count)
  );

  i2cs_fsm #(.W(RELOAD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .start_bit(ctl_wdata[CTL_START]),
    .reload(reload), .sda_s(line_s[0]), .scl_s(line_s[1]), .timeout(timeout),
    .done_clr(flag_clr[FLAG_DONE]), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .cnt_run(cnt_run), .sda_hold(sda_hold), .busy(busy), .ev_accept(ev_accept),
    .ev_abort(ev_abort), .ev_edge(ev_edge), .ev_finish(ev_finish)
  );

  i2cs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .flag_clr(flag_clr), .busy(busy),
    .ev_abort(ev_abort), .ev_edge(ev_edge), .ev_finish(ev_finish),
    .ctl_q(ctl_q), .buf_q(buf_q), .flags(flags)
  );

  assign sda_drive_low = sda_hold;
  assign scl_drive_low = 1'b0;
  assign start_seen    = flags[FLAG_SEEN];
  assign start_done    = flags[FLAG_DONE];
  assign bus_coll      = flags[FLAG_BCOL];
  assign wr_coll       = flags[FLAG_WCOL];

  p_seen_with_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> start_seen);

  p_accept_needs_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (count != '0));

  p_sda_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> $past(busy));
endmodule

// File: tb/tb_i2c_start_gen.sv
module tb_i2c_start_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, ctl_wr, buf_wr, fault_sda, fault_scl;
  logic [4:0] ctl_wdata;
  logic [7:0] reload, buf_wdata;
  logic [3:0] flag_clr;
  logic       sda_drive_low, scl_drive_low, start_seen, start_done, bus_coll, wr_coll;
  logic [4:0] ctl_q;
  logic [7:0] buf_q;
  logic       sda_pin, scl_pin;

  // Wired-AND bus with pull-ups: any driver or fault pulls the line low.
  assign sda_pin = !sda_drive_low && !fault_sda;
  assign scl_pin = !scl_drive_low && !fault_scl;

  i2c_start_gen dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .reload(reload),
    .sda_in(sda_pin), .scl_in(scl_pin), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .flag_clr(flag_clr), .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .ctl_q(ctl_q), .buf_q(buf_q), .start_seen(start_seen), .start_done(start_done),
    .bus_coll(bus_coll), .wr_coll(wr_coll)
  );

  int vectors = 0, fails = 0, cycles = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase number, remaining cycles, and a line history queue.
  int       m_ph, m_left;
  bit       m_hold, m_seen, m_done, m_bcol, m_wcol;
  bit [4:0] m_ctl;
  bit [7:0] m_buf;
  bit       sda_hist[$], scl_hist[$];

  always @(posedge clk) begin
    bit s_sda, s_scl, hi, req, tmo, acc, abrt, edg, fin, busy, l_sda, l_scl;
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_hold = 0; m_seen = 0; m_done = 0; m_bcol = 0; m_wcol = 0;
      m_ctl = 0; m_buf = 0;
      sda_hist = '{1'b1, 1'b1}; scl_hist = '{1'b1, 1'b1};
    end else begin
      s_sda = sda_hist[0]; s_scl = scl_hist[0];
      l_sda = !m_hold && !fault_sda; l_scl = !fault_scl;
      hi   = s_sda && s_scl;
      req  = (m_ph == 0) && ctl_wr && ctl_wdata[0];
      tmo  = (m_ph != 0) && (m_left == 1);
      acc  = req && hi;
      abrt = (req && !hi) || (m_ph == 1 && !hi);
      edg  = (m_ph == 1) && hi && tmo;
      fin  = (m_ph == 2) && tmo;
      busy = (m_ph != 0);
      if (buf_wr && !busy) m_buf = buf_wdata;
      if (ctl_wr && !busy) m_ctl = ctl_wdata;
      if (abrt || fin) m_ctl[0] = 1'b0;
      if (flag_clr[0]) m_seen = 0;
      if (flag_clr[1]) m_done = 0;
      if (flag_clr[2]) m_bcol = 0;
      if (flag_clr[3]) m_wcol = 0;
      if (edg) m_seen = 1;
      if (fin) m_done = 1;
      if (abrt) m_bcol = 1;
      if (buf_wr && busy) m_wcol = 1;
      if (m_ph == 0 && flag_clr[1]) m_hold = 0;
      if (edg) m_hold = 1;
      if (acc) begin m_ph = 1; m_left = (reload % 128 == 0) ? 1 : reload % 128; end
      else if (abrt) m_ph = 0;
      else if (edg) begin m_ph = 2; m_left = (reload == 0) ? 1 : reload; end
      else if (fin) m_ph = 0;
      else if (m_ph != 0 && m_left > 1) m_left--;
      void'(sda_hist.pop_front()); sda_hist.push_back(l_sda);
      void'(scl_hist.pop_front()); scl_hist.push_back(l_scl);
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "sda_drive_low", sda_drive_low, m_hold);
      chk("R2", "scl_drive_low", scl_drive_low, 0);
      chk("R9", "ctl_q", ctl_q, m_ctl);
      chk("R8", "buf_q", buf_q, m_buf);
      chk("R3", "start_seen", start_seen, m_seen);
      chk("R4", "start_done", start_done, m_done);
      chk("R6", "bus_coll", bus_coll, m_bcol);
      chk("R8", "wr_coll", wr_coll, m_wcol);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    flag_clr = 4'hF; @(negedge clk); flag_clr = 4'h0; idle(4);
  endtask

  task automatic request();
    ctl_wdata = 5'b00001; ctl_wr = 1'b1; @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 5'b0;
  endtask

  // R1/R4/R5/R10: measure both half-phases against the reload arithmetic.
  task automatic timed_start(input logic [7:0] rv);
    int n1, m, c;
    reload = rv;
    n1 = (rv % 128 == 0) ? 1 : rv % 128;
    m  = (rv == 0) ? 1 : rv;
    request();
    c = 0;
    while (!sda_drive_low && c < 400) begin @(negedge clk); c++; end
    chk("R1", "cycles until SDA pulled low", c, n1);
    c = 0;
    while (!start_done && c < 400) begin @(negedge clk); c++; end
    chk("R4", "cycles from SDA low to done", c, m);
    chk("R4", "start bit after done", ctl_q[0], 0);
    idle(3);
    chk("R5", "SDA held after done", sda_drive_low, 1);
    flag_clr = 4'b0010; @(negedge clk); flag_clr = 4'b0;
    chk("R5", "SDA released by done clear", sda_drive_low, 0);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 0; ctl_wdata = 0; reload = 8'd3; buf_wr = 0; buf_wdata = 0;
    flag_clr = 0; fault_sda = 0; fault_scl = 0;
    idle(3);
    // R12: reset state
    chk("R12", "sda_drive_low", sda_drive_low, 0);
    chk("R12", "flags", {start_seen, start_done, bus_coll, wr_coll}, 0);
    chk("R12", "ctl_q", ctl_q, 0);
    chk("R12", "buf_q", buf_q, 0);
    rst_n = 1'b1;
    idle(3);

    timed_start(8'd3);
    timed_start(8'd0);      // R10: zero reload floors at one cycle
    timed_start(8'h85);     // R1 vs R4: seven-bit and eight-bit views differ

    // R8 idle load, then R8/R9/R11 during a long start.
    buf_wdata = 8'h3C; buf_wr = 1; @(negedge clk); buf_wr = 0;
    chk("R8", "idle buffer load", buf_q, 8'h3C);
    reload = 8'h85;
    request();
    idle(2);
    buf_wdata = 8'hA5; buf_wr = 1; @(negedge clk); buf_wr = 0;
    chk("R8", "buffer unchanged while busy", buf_q, 8'h3C);
    chk("R8", "write collision flagged", wr_coll, 1);
    ctl_wdata = 5'b11110; ctl_wr = 1; @(negedge clk); ctl_wr = 0; ctl_wdata = 0;
    chk("R9", "control bits ignored while busy", ctl_q, 5'b00001);
    buf_wdata = 8'h11; buf_wr = 1; flag_clr = 4'b1000; @(negedge clk);
    buf_wr = 0; flag_clr = 0;
    chk("R11", "set beats clear", wr_coll, 1);
    flag_clr = 4'b1000; @(negedge clk); flag_clr = 0;
    chk("R11", "write-one clears", wr_coll, 0);
    idle(150);
    chk("R4", "long start completed", start_done, 1);
    flag_clr = 4'b0010; @(negedge clk); flag_clr = 0;
    clear_all();

    // R9: idle control write loads all bits.
    ctl_wdata = 5'b10100; ctl_wr = 1; @(negedge clk); ctl_wr = 0; ctl_wdata = 0;
    chk("R9", "idle control write", ctl_q, 5'b10100);
    ctl_wdata = 5'b00000; ctl_wr = 1; @(negedge clk); ctl_wr = 0;

    // R6: SDA already low at the request.
    fault_sda = 1; idle(3);
    reload = 8'd5;
    request();
    chk("R6", "collision at request", bus_coll, 1);
    chk("R6", "start bit dropped", ctl_q[0], 0);
    idle(6);
    chk("R6", "no drive after abort", sda_drive_low, 0);
    chk("R6", "no start produced", start_seen, 0);
    fault_sda = 0; clear_all();

    // R7: SCL pulled low during the first half-phase.
    reload = 8'd20;
    request();
    idle(4);
    fault_scl = 1; idle(6);
    chk("R7", "SCL fault collision", bus_coll, 1);
    chk("R7", "start bit cleared", ctl_q[0], 0);
    chk("R7", "no start produced", start_seen, 0);
    idle(20);
    chk("R7", "SDA never driven", sda_drive_low, 0);
    fault_scl = 0; clear_all();

    // R7: SDA pulled low during the first half-phase.
    request();
    idle(5);
    fault_sda = 1; idle(6);
    chk("R7", "SDA fault collision", bus_coll, 1);
    chk("R7", "no start after SDA fault", start_seen, 0);
    fault_sda = 0; clear_all();

    timed_start(8'd1);
    idle(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected under 50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule